// File: doc/BRIEF.md
# Real FFT Split Post-Processor

This block takes the N complex outputs of an N-point FFT and produces the spectrum of a 2N-point real sequence. Upstream logic packs the real sequence into a complex one: even-numbered samples go to the real part and odd-numbered samples to the imaginary part. Call the FFT output of that packed sequence Z. For every index k, the block pairs Z(k) with Z((N-k) mod N) and separates two spectra. H(k) is the spectrum of the even samples and G(k) is the spectrum of the odd samples. It then rotates G(k) by the 2N-point twiddle e^(-jπk/N) and emits the sum and the difference of the two as bins k and k+N.

A frame of N samples arrives in natural order, Z(0) first, on cycles where `in_valid` is high. It is held in a small register file so that both members of each pair can be read in the same cycle. Once the frame is complete, the block streams N result cycles in ascending k. Each cycle carries the low bin X(k), the high bin X(k+N) and the index k. Bins 0 to N cover every distinct non-negative frequency, and bin N appears as the high bin of index 0. N must be a power of two; the default is 16, which gives a 32-point real transform.

Top module: `rsplit_post`

## Requirements
- R1: On the cycle after `rst` is sampled high, `out_valid` is 0.
- R2: In the fill phase, a sample is taken only on a clock edge where `in_valid` is 1. The m-th accepted sample (m = 0..N-1) is Z(m). Edges with `in_valid` low do not advance the frame.
- R3: From the edge after the one that accepts the N-th sample, `out_valid` is 1 for exactly N consecutive cycles. During those cycles `out_idx` takes the values 0, 1, ..., N-1 in order. After that, `out_valid` is 0 until the next frame completes.
- R4: Let a = Z(k) and b = Z((N-k) mod N). Define h2r = ar+br, h2i = ai-bi, g2r = ai+bi and g2i = br-ar. Define pr = C·g2r + S·g2i and pi = C·g2i − S·g2r. Then `out_lo_re` = (2^(TW-2)·h2r + pr + 2^(TW-2)) >>> (TW-1), and `out_lo_im` is formed the same way from h2i and pi. Here >>> is an arithmetic (floor) shift, and all values are two's complement.
- R5: `out_hi_re` and `out_hi_im` (bin k+N) follow the R4 formula with −pr and −pi in place of pr and pi.
- R6: The twiddle for index k is C = round(cos(πk/N)·2^(TW-2)) and S = round(sin(πk/N)·2^(TW-2)), with exact halves rounded upward.
- R7: For index 0, `out_lo_re` = Re Z(0) + Im Z(0) and `out_hi_re` = Re Z(0) − Im Z(0), and both imaginary outputs are 0.
- R8: Samples presented on the N edges that produce the result cycles are ignored. The next frame starts with the first sample accepted on an edge after the edge that produces index N-1.
- R9: A reset during the fill phase discards the partial frame. The next N accepted samples form a new frame.
- R10: Outputs are DW+2 bits wide, so full-scale inputs (components at −2^(DW-1) or 2^(DW-1)−1) produce correct results without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_re | input | DW | Real part of FFT output sample, signed |
| in_im | input | DW | Imaginary part of FFT output sample, signed |
| out_valid | output | 1 | Result cycle present |
| out_idx | output | log2(N) | Bin index k of this result cycle |
| out_lo_re | output | DW+2 | Real part of X(k), signed |
| out_lo_im | output | DW+2 | Imaginary part of X(k), signed |
| out_hi_re | output | DW+2 | Real part of X(k+N), signed |
| out_hi_im | output | DW+2 | Imaginary part of X(k+N), signed |

## Verification
If the fill counter slips, or if it counts idle or ignored cycles, the burst of `out_valid` starts on the wrong edge and every bin of that frame is built from shifted samples. The per-clock comparison catches this within one frame. A wrong partner address or a wrong twiddle entry leaves index 0 correct (and index N/2 for the partner address) but corrupts the other indices. These errors appear in the first frame that has nonzero data there. A phase that fails to return to fill shows up as a missing or extra valid cycle directly after the N-th result, or as a next frame that never starts.

// File: rtl/rsplit_pkg.sv
package rsplit_pkg;

    typedef enum logic {
        PH_FILL = 1'b0,
        PH_EMIT = 1'b1
    } phase_e;

    // Quantised twiddle component: round(trig(pi*k/n) * 2^(tw-2)), halves up
    function automatic int twid_q(input int k, input int n, input int tw, input bit want_sin);
        real ang;
        real v;
        real scale;
        scale = 1.0;
        for (int i = 0; i < tw - 2; i++) begin
            scale = scale * 2.0;
        end
        ang = 3.141592653589793 * real'(k) / real'(n);
        v   = want_sin ? $sin(ang) : $cos(ang);
        return $rtoi($floor(v * scale + 0.5));
    endfunction

endpackage

// File: rtl/rsplit_ctrl.sv
module rsplit_ctrl
    import rsplit_pkg::*;
#(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          wr_en,
    output logic [IW-1:0] wr_addr,
    output logic          emit,
    output logic [IW-1:0] bin_k
);

    localparam logic [IW-1:0] LAST = IW'(N - 1);

    phase_e        phase;
    logic [IW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_FILL;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_FILL: begin
                    if (in_valid) begin
                        cnt <= cnt + IW'(1);
                        if (cnt == LAST) begin
                            phase <= PH_EMIT;
                        end
                    end
                end
                PH_EMIT: begin
                    cnt <= cnt + IW'(1);
                    if (cnt == LAST) begin
                        phase <= PH_FILL;
                    end
                end
                default: phase <= PH_FILL;
            endcase
        end
    end

    always_comb begin
        wr_en   = (phase == PH_FILL) && in_valid;
        wr_addr = cnt;
        emit    = (phase == PH_EMIT);
        bin_k   = cnt;
    end

    AST_FILL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FILL && !in_valid) |=> $stable(cnt)); // R2

    AST_EMIT_RUN: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EMIT && cnt != LAST) |=> (phase == PH_EMIT)); // R3

endmodule

// File: rtl/rsplit_frame_buf.sv
module rsplit_frame_buf #(
    parameter int N  = 16,
    parameter int DW = 16,
    localparam int IW = $clog2(N),
    localparam int EW = 2 * DW
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_addr,
    input  logic [DW-1:0] wr_re,
    input  logic [DW-1:0] wr_im,
    input  logic [IW-1:0] rd_k,
    output logic [EW-1:0] rd_a,
    output logic [EW-1:0] rd_b
);

    logic [EW-1:0] mem [N];
    logic [IW-1:0] partner;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= {wr_re, wr_im};
        end
    end

    // (N - k) mod N for a power-of-two N
    always_comb begin
        partner = ~rd_k + IW'(1);
        rd_a    = mem[rd_k];
        rd_b    = mem[partner];
    end

endmodule

// File: rtl/rsplit_split_calc.sv
module rsplit_split_calc
    import rsplit_pkg::*;
#(
    parameter int N  = 16,
    parameter int DW = 16,
    parameter int TW = 16,
    localparam int IW = $clog2(N),
    localparam int EW = 2 * DW,
    localparam int HW = DW + 1,
    localparam int AW = DW + TW + 3,
    localparam int OW = DW + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 emit,
    input  logic [IW-1:0]        bin_k,
    input  logic [EW-1:0]        za,
    input  logic [EW-1:0]        zb,
    output logic                 out_valid,
    output logic [IW-1:0]        out_idx,
    output logic signed [OW-1:0] out_lo_re,
    output logic signed [OW-1:0] out_lo_im,
    output logic signed [OW-1:0] out_hi_re,
    output logic signed [OW-1:0] out_hi_im
);

    typedef struct packed {
        logic signed [DW-1:0] re;
        logic signed [DW-1:0] im;
    } samp_t;

    typedef struct packed {
        logic signed [HW-1:0] hr;
        logic signed [HW-1:0] hi;
        logic signed [HW-1:0] gr;
        logic signed [HW-1:0] gi;
    } parts_t;

    localparam logic signed [AW-1:0] RND = AW'(1) <<< (TW - 2);

    logic signed [TW-1:0] cos_tab [N];
    logic signed [TW-1:0] sin_tab [N];

    for (genvar g = 0; g < N; g++) begin : g_tw
        localparam int CQ = twid_q(g, N, TW, 1'b0);
        localparam int SQ = twid_q(g, N, TW, 1'b1);
        assign cos_tab[g] = TW'(CQ);
        assign sin_tab[g] = TW'(SQ);
    end

    samp_t                a, b;
    parts_t               pt;
    logic signed [TW-1:0] c, s;
    logic signed [AW-1:0] pr, pim, hr_s, hi_s;
    logic signed [OW-1:0] lo_re_n, lo_im_n, hi_re_n, hi_im_n;

    always_comb begin
        a     = samp_t'(za);
        b     = samp_t'(zb);
        pt.hr = HW'(a.re) + HW'(b.re);
        pt.hi = HW'(a.im) - HW'(b.im);
        pt.gr = HW'(a.im) + HW'(b.im);
        pt.gi = HW'(b.re) - HW'(a.re);
        c     = cos_tab[bin_k];
        s     = sin_tab[bin_k];
        pr    = AW'(c) * AW'(pt.gr) + AW'(s) * AW'(pt.gi);
        pim   = AW'(c) * AW'(pt.gi) - AW'(s) * AW'(pt.gr);
        hr_s  = AW'(pt.hr) <<< (TW - 2);
        hi_s  = AW'(pt.hi) <<< (TW - 2);
        lo_re_n = OW'((hr_s + pr  + RND) >>> (TW - 1));
        lo_im_n = OW'((hi_s + pim + RND) >>> (TW - 1));
        hi_re_n = OW'((hr_s - pr  + RND) >>> (TW - 1));
        hi_im_n = OW'((hi_s - pim + RND) >>> (TW - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_idx   <= '0;
            out_lo_re <= '0;
            out_lo_im <= '0;
            out_hi_re <= '0;
            out_hi_im <= '0;
        end else begin
            out_valid <= emit;
            out_idx   <= bin_k;
            out_lo_re <= lo_re_n;
            out_lo_im <= lo_im_n;
            out_hi_re <= hi_re_n;
            out_hi_im <= hi_im_n;
        end
    end

    AST_DC_REAL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_idx == '0) |-> (out_lo_im == '0 && out_hi_im == '0)); // R7

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_idx != IW'(N - 1)) |=> (out_valid && out_idx == $past(out_idx) + IW'(1))); // R3

    AST_IDX_START: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (out_idx == '0)); // R3

endmodule

// File: rtl/rsplit_post.sv
module rsplit_post #(
    parameter int N  = 16,
    parameter int DW = 16,
    parameter int TW = 16,
    localparam int IW = $clog2(N),
    localparam int EW = 2 * DW,
    localparam int OW = DW + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    output logic                 out_valid,
    output logic [IW-1:0]        out_idx,
    output logic signed [OW-1:0] out_lo_re,
    output logic signed [OW-1:0] out_lo_im,
    output logic signed [OW-1:0] out_hi_re,
    output logic signed [OW-1:0] out_hi_im
);

    logic          wr_en;
    logic [IW-1:0] wr_addr;
    logic          emit;
    logic [IW-1:0] bin_k;
    logic [EW-1:0] za, zb;

    rsplit_ctrl #(.N(N)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .emit     (emit),
        .bin_k    (bin_k)
    );

    rsplit_frame_buf #(.N(N), .DW(DW)) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_re   (in_re),
        .wr_im   (in_im),
        .rd_k    (bin_k),
        .rd_a    (za),
        .rd_b    (zb)
    );

    rsplit_split_calc #(.N(N), .DW(DW), .TW(TW)) u_calc (
        .clk       (clk),
        .rst       (rst),
        .emit      (emit),
        .bin_k     (bin_k),
        .za        (za),
        .zb        (zb),
        .out_valid (out_valid),
        .out_idx   (out_idx),
        .out_lo_re (out_lo_re),
        .out_lo_im (out_lo_im),
        .out_hi_re (out_hi_re),
        .out_hi_im (out_hi_im)
    );

    AST_RST_QUIET: assert property (@(posedge clk)
        rst |=> !out_valid); // R1

endmodule

// File: tb/rsplit_post_bench.sv
module rsplit_post_bench;

    localparam int N  = 16;
    localparam int DW = 16;
    localparam int TW = 16;
    localparam int IW = $clog2(N);
    localparam int OW = DW + 2;
    localparam int SMAX = (1 << (DW - 1)) - 1;
    localparam int SMIN = -(1 << (DW - 1));

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_re = '0;
    logic signed [DW-1:0] in_im = '0;
    logic                 out_valid;
    logic [IW-1:0]        out_idx;
    logic signed [OW-1:0] out_lo_re, out_lo_im, out_hi_re, out_hi_im;

    always #4 clk = ~clk;

    rsplit_post #(.N(N), .DW(DW), .TW(TW)) u_rsplit_post (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_re (in_re), .in_im (in_im),
        .out_valid (out_valid), .out_idx (out_idx),
        .out_lo_re (out_lo_re), .out_lo_im (out_lo_im),
        .out_hi_re (out_hi_re), .out_hi_im (out_hi_im)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    string ctx      = "R1";

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] %s: actual=%0d expected=%0d", req, ctx, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int     fr_re [N];
    int     fr_im [N];
    int     fill_cnt = 0;
    bit     emitting = 1'b0;
    int     emit_k   = 0;
    bit     started  = 1'b0;
    bit     exp_valid = 1'b0;
    int     exp_idx  = 0;
    longint e_lo_re, e_lo_im, e_hi_re, e_hi_im;
    int     z0_re, z0_im;

    function automatic longint tw_val(input int k, input bit want_sin);
        real sc = real'(longint'(1) << (TW - 2));
        real a  = 3.141592653589793 * real'(k) / real'(N);
        real v  = want_sin ? $sin(a) : $cos(a);
        return longint'($rtoi($floor(v * sc + 0.5)));
    endfunction

    function automatic longint scale_round(input longint v);
        return (v + (longint'(1) <<< (TW - 2))) >>> (TW - 1);
    endfunction

    task automatic model_bin(input int k);
        int     p = (N - k) % N;
        longint ar = fr_re[k], ai = fr_im[k], br = fr_re[p], bi = fr_im[p];
        longint h2r = ar + br, h2i = ai - bi, g2r = ai + bi, g2i = br - ar;
        longint c = tw_val(k, 1'b0), s = tw_val(k, 1'b1);
        longint pr = c * g2r + s * g2i;
        longint pi = c * g2i - s * g2r;
        longint hrs = h2r * (longint'(1) <<< (TW - 2));
        longint his = h2i * (longint'(1) <<< (TW - 2));
        e_lo_re = scale_round(hrs + pr);
        e_lo_im = scale_round(his + pi);
        e_hi_re = scale_round(hrs - pr);
        e_hi_im = scale_round(his - pi);
    endtask

    always @(posedge clk) begin
        started = 1'b1;
        if (rst) begin
            fill_cnt  = 0;
            emitting  = 1'b0;
            exp_valid = 1'b0;
        end else if (emitting) begin
            exp_valid = 1'b1;
            exp_idx   = emit_k;
            model_bin(emit_k);
            emit_k++;
            if (emit_k == N) emitting = 1'b0;
        end else begin
            exp_valid = 1'b0;
            if (in_valid) begin
                fr_re[fill_cnt] = int'(in_re);
                fr_im[fill_cnt] = int'(in_im);
                fill_cnt++;
                if (fill_cnt == N) begin
                    fill_cnt = 0;
                    emitting = 1'b1;
                    emit_k   = 0;
                    z0_re    = fr_re[0];
                    z0_im    = fr_im[0];
                end
            end
        end
    end

    // ---------------- per-clock comparison ----------------
    always @(negedge clk) begin
        if (started) begin
            check(out_valid == exp_valid, "R3", "out_valid", out_valid, exp_valid);
            if (out_valid && exp_valid) begin
                check(int'(out_idx) == exp_idx, "R3", "out_idx", out_idx, exp_idx);
                check(longint'(out_lo_re) == e_lo_re, "R4", "lo_re", out_lo_re, e_lo_re);
                check(longint'(out_lo_im) == e_lo_im, "R4", "lo_im", out_lo_im, e_lo_im);
                check(longint'(out_hi_re) == e_hi_re, "R5", "hi_re", out_hi_re, e_hi_re);
                check(longint'(out_hi_im) == e_hi_im, "R5", "hi_im", out_hi_im, e_hi_im);
                if (exp_idx == 0) begin
                    check(longint'(out_lo_re) == longint'(z0_re) + z0_im, "R7", "bin0 re",
                          out_lo_re, longint'(z0_re) + z0_im);
                    check(longint'(out_hi_re) == longint'(z0_re) - z0_im, "R7", "binN re",
                          out_hi_re, longint'(z0_re) - z0_im);
                    check(out_lo_im == '0 && out_hi_im == '0, "R7", "bin0/binN imag nonzero",
                          out_lo_im, 0);
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic push(input int re, input int im);
        @(negedge clk);
        in_valid = 1'b1;
        in_re    = DW'(re);
        in_im    = DW'(im);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic rand_frame(input bit gaps);
        for (int m = 0; m < N; m++) begin
            if (gaps && (m % 3 == 1)) idle(2);
            push(int'($signed(DW'($urandom))), int'($signed(DW'($urandom))));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid during reset", out_valid, 0);
        rst = 1'b0;
        idle(3);

        ctx = "R2 R6 contiguous";
        rand_frame(1'b0);
        idle(N + 4);

        ctx = "R2 gaps";
        rand_frame(1'b1);
        idle(N + 4);

        ctx = "R10 full-scale";
        for (int m = 0; m < N; m++)
            push((m % 2 == 1) ? SMAX : SMIN, (m % 3 == 0) ? SMIN : SMAX);
        idle(N + 4);

        ctx = "R10 all-min";
        for (int m = 0; m < N; m++) push(SMIN, SMIN);
        idle(N + 4);

        ctx = "R8 ignored during emission";
        for (int m = 0; m < N; m++) push((m == 1) ? 1000 : 0, (m == 2) ? -700 : 0);
        for (int m = 0; m < N; m++) push(12345, -23456);
        rand_frame(1'b0);
        idle(N + 4);

        ctx = "R9 reset mid-fill";
        for (int m = 0; m < N / 2; m++) push(5000 + m, -m);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        rst = 1'b0;
        rand_frame(1'b0);
        idle(N + 4);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R3 watchdog: cycles=%0d expected < %0d", 20000, 20000);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule